// File: doc/BRIEF.md
# Accumulator ALU with Selective Status Update

This block is the arithmetic and logic stage of a small accumulator machine. In one cycle it takes an operation code, an accumulator operand, a second operand and the present status byte. It returns the result and the status byte the operation would produce. The result and the proposed status are combinational. A status register inside the block takes the proposed status on any clock edge where the update strobe is high, and its value is driven on `flags_o`.

Each operation writes its own fixed set of flags and passes every other status bit through unchanged. Operations that modify memory (shift, rotate, increment, decrement, test-and-set and test-and-reset) act on `b_i`, which plays the role of the destination. When the decimal flag is set, add and subtract correct each 4-bit digit to binary-coded decimal.

No data stream crosses this boundary, so the block has no valid/ready pair. The update strobe is a plain control input. The block accepts it on every cycle and never applies back-pressure.

Top module: `alu8_core`

## Requirements
- R1: Status bits are N=7, V=6, Z=1, C=0. For every operation, `nxt_o[5:2]` equals `st_i[5:2]`, so the break, decimal and interrupt-disable bits are never modified.
- R2: ADC (op 0) with D=`st_i[3]`=0 gives `a+b+C`. C is the carry out. V is set when `a` and `b` share a sign bit and the result's sign differs from it. N and Z follow the result.
- R3: SBC (op 1) with D=0 gives `a+~b+C`, which is `a-b-(1-C)`. C is set when no borrow occurs. V uses the rule of R2 applied to `a` and `~b`. N and Z follow the result.
- R4: With D=1, ADC and SBC correct each digit to decimal. C comes from the top digit's decimal carry or borrow, and N and Z follow the corrected byte. V keeps the binary rule. For example, 0x99+0x01 with C=0 gives 0x00 with C=1.
- R5: AND (2), OR (3), XOR (4) of `a` and `b`, INC (9) and DEC (10) of `b`, and LD (15), which passes `b`, write only N and Z. V and C are unchanged.
- R6: ASL (5) shifts `b` left, fills bit 0 with 0 and moves bit 7 into C. LSR (6) shifts `b` right, fills bit 7 with 0, moves bit 0 into C and leaves N at 0. Both write N, Z and C.
- R7: ROL (7) and ROR (8) rotate `b` through C as a 9-bit loop and write N, Z and C.
- R8: CMP (11) computes `a-b`, drives `a` unchanged on `res_o`, sets C when `a>=b`, sets N and Z from the difference, and leaves V unchanged.
- R9: BIT (12) drives `a` on `res_o`. It sets Z when `a&b` is zero, copies `b[7]` to N and `b[6]` to V, and leaves C unchanged.
- R10: TRB (13) gives `b & ~a` and TSB (14) gives `b | a`. Both set Z when `a&b` is zero and leave N, V and C unchanged.
- R11: After reset `flags_o` is 0x00. On a clock edge with `upd_i` high, `flags_o` takes the `nxt_o` of that cycle. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Source or destination operand |
| st_i | input | 8 | Present status byte |
| upd_i | input | 1 | Status register load strobe |
| res_o | output | 8 | Result |
| nxt_o | output | 8 | Proposed next status byte |
| flags_o | output | 8 | Registered status byte |

## Verification
The bench builds the block with the default data width of 8. At that width the decimal path is a two-digit chain, so a random sweep with mixed decimal flags exercises the carry or borrow passed between the digits as well as the digit-to-byte carry. The narrow operands also let a few thousand random cycles reach the sign and zero corners of every operation, for both carry-in values. Directed vectors cover 0x99+1 in decimal, 0-1 in decimal, signed overflow in both directions, and a compare of equal operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADC = 4'h0, OP_SBC = 4'h1, OP_AND = 4'h2, OP_OR  = 4'h3,
    OP_XOR = 4'h4, OP_ASL = 4'h5, OP_LSR = 4'h6, OP_ROL = 4'h7,
    OP_ROR = 4'h8, OP_INC = 4'h9, OP_DEC = 4'hA, OP_CMP = 4'hB,
    OP_BIT = 4'hC, OP_TRB = 4'hD, OP_TSB = 4'hE, OP_LD  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {CLS_ARITH, CLS_LOGIC, CLS_SHIFT} alu_cls_e;

  // Flag values or write enables, one per writable flag
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flag4_t;

  localparam int STW   = 8;
  localparam int POS_N = 7;
  localparam int POS_V = 6;
  localparam int POS_D = 3;
  localparam int POS_Z = 1;
  localparam int POS_C = 0;

  function automatic alu_cls_e cls_of(alu_op_e op);
    case (op)
      OP_ADC, OP_SBC, OP_CMP:                         cls_of = CLS_ARITH;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_INC, OP_DEC: cls_of = CLS_SHIFT;
      default:                                        cls_of = CLS_LOGIC;
    endcase
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  input  logic            dec,
  output logic [DW-1:0]   res,
  output flag4_t          fl,
  output flag4_t          wr
);
  localparam int NIB = DW / 4;
  localparam int MSB = DW - 1;

  logic          sub;
  logic [DW-1:0] bo;
  logic          ci;
  logic [DW:0]   bsum;
  logic [NIB:0]  dc;
  logic [DW-1:0] dsum;
  logic          v_bin;
  logic          use_dec;
  logic [DW-1:0] r;
  logic          c;

  assign sub     = (op != OP_ADC);
  assign bo      = sub ? ~b : b;
  assign ci      = (op == OP_CMP) ? 1'b1 : cin;
  assign bsum    = {1'b0, a} + {1'b0, bo} + {{DW{1'b0}}, ci};
  assign v_bin   = (a[MSB] == bo[MSB]) && (bsum[MSB] != a[MSB]);
  assign use_dec = dec && (op != OP_CMP);
  assign dc[0]   = ci;

  // Decimal digit chain: one stage per 4-bit digit
  for (genvar g = 0; g < NIB; g++) begin : g_dig
    logic [4:0] t;
    logic       cy;
    assign t  = {1'b0, a[4*g +: 4]} + {1'b0, bo[4*g +: 4]} + {4'd0, dc[g]};
    assign cy = sub ? t[4] : (t > 5'd9);
    assign dc[g+1] = cy;
    assign dsum[4*g +: 4] = sub ? (cy ? t[3:0] : t[3:0] + 4'd10)
                                : (cy ? t[3:0] + 4'd6 : t[3:0]);
  end

  assign r = use_dec ? dsum : bsum[MSB:0];
  assign c = use_dec ? dc[NIB] : bsum[DW];

  always_comb begin
    res = a;
    fl  = '0;
    wr  = '0;
    case (op)
      OP_ADC, OP_SBC: begin
        res  = r;
        fl.n = r[MSB];
        fl.v = v_bin;
        fl.z = (r == '0);
        fl.c = c;
        wr   = 4'b1111;
      end
      OP_CMP: begin
        res  = a;
        fl.n = bsum[MSB];
        fl.z = (bsum[MSB:0] == '0);
        fl.c = bsum[DW];
        wr   = 4'b1011;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output flag4_t          fl,
  output flag4_t          wr
);
  localparam int MSB = DW - 1;

  logic mask_zero;
  assign mask_zero = ((a & b) == '0);

  always_comb begin
    res = a;
    fl  = '0;
    wr  = '0;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_LD: begin
        case (op)
          OP_AND:  res = a & b;
          OP_OR:   res = a | b;
          OP_XOR:  res = a ^ b;
          default: res = b;
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0);
        wr   = 4'b1010;
      end
      OP_BIT: begin
        res  = a;
        fl.n = b[MSB];
        fl.v = b[MSB-1];
        fl.z = mask_zero;
        wr   = 4'b1110;
      end
      OP_TRB, OP_TSB: begin
        res  = (op == OP_TRB) ? (b & ~a) : (b | a);
        fl.z = mask_zero;
        wr   = 4'b0010;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output flag4_t          fl,
  output flag4_t          wr
);
  localparam int MSB = DW - 1;

  logic cout;

  always_comb begin
    res  = b;
    cout = 1'b0;
    wr   = '0;
    case (op)
      OP_ASL: begin {cout, res} = {b, 1'b0}; wr = 4'b1011; end
      OP_LSR: begin {res, cout} = {1'b0, b}; wr = 4'b1011; end
      OP_ROL: begin {cout, res} = {b, cin};  wr = 4'b1011; end
      OP_ROR: begin {res, cout} = {cin, b};  wr = 4'b1011; end
      OP_INC: begin res = b + 1'b1;          wr = 4'b1010; end
      OP_DEC: begin res = b - 1'b1;          wr = 4'b1010; end
      default: ;
    endcase
    fl.n = res[MSB];
    fl.v = 1'b0;
    fl.z = (res == '0);
    fl.c = cout;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [STW-1:0]  st_i,
  input  logic            upd_i,
  output logic [DW-1:0]   res_o,
  output logic [STW-1:0]  nxt_o,
  output logic [STW-1:0]  flags_o
);
  alu_op_e       op;
  logic [DW-1:0] ar_res, lg_res, sh_res;
  flag4_t        ar_fl, lg_fl, sh_fl;
  flag4_t        ar_wr, lg_wr, sh_wr;
  flag4_t        sel_fl, sel_wr;
  logic [STW-1:0] nxt;
  logic [STW-1:0] flags_q;

  assign op = alu_op_e'(op_i);

  alu8_arith #(.DW(DW)) u_arith (
    .op(op), .a(a_i), .b(b_i), .cin(st_i[POS_C]), .dec(st_i[POS_D]),
    .res(ar_res), .fl(ar_fl), .wr(ar_wr)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op), .a(a_i), .b(b_i),
    .res(lg_res), .fl(lg_fl), .wr(lg_wr)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op(op), .b(b_i), .cin(st_i[POS_C]),
    .res(sh_res), .fl(sh_fl), .wr(sh_wr)
  );

  always_comb begin
    case (cls_of(op))
      CLS_ARITH: begin res_o = ar_res; sel_fl = ar_fl; sel_wr = ar_wr; end
      CLS_SHIFT: begin res_o = sh_res; sel_fl = sh_fl; sel_wr = sh_wr; end
      default:   begin res_o = lg_res; sel_fl = lg_fl; sel_wr = lg_wr; end
    endcase
  end

  // Write-masked merge: untouched bits flow from st_i
  always_comb begin
    nxt = st_i;
    if (sel_wr.n) nxt[POS_N] = sel_fl.n;
    if (sel_wr.v) nxt[POS_V] = sel_fl.v;
    if (sel_wr.z) nxt[POS_Z] = sel_fl.z;
    if (sel_wr.c) nxt[POS_C] = sel_fl.c;
  end

  assign nxt_o = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (upd_i) flags_q <= nxt;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [7:0]    st_i,
  input logic          upd_i,
  input logic [DW-1:0] res_o,
  input logic [7:0]    nxt_o,
  input logic [7:0]    flags_o
);
  // R1
  keep_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_o[5:2] == st_i[5:2]);

  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> flags_o == $past(nxt_o));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_o));

  // R8
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'hB |-> (res_o == a_i) && (nxt_o[6] == st_i[6]));

  // R6
  lsr_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'h6 |-> !nxt_o[7] && (nxt_o[0] == b_i[0]));

  // R9
  bit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'hC |-> (nxt_o[7:6] == b_i[DW-1 -: 2]) && (nxt_o[0] == st_i[0]));

  // R10
  tsb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'hD || op_i == 4'hE) |-> (nxt_o[7:6] == st_i[7:6]) && (nxt_o[0] == st_i[0]));

  // R5
  logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i inside {4'h2, 4'h3, 4'h4, 4'h9, 4'hA, 4'hF}) |->
      (nxt_o[6] == st_i[6]) && (nxt_o[0] == st_i[0]));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .st_i(st_i), .upd_i(upd_i), .res_o(res_o), .nxt_o(nxt_o), .flags_o(flags_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0, st_i = '0;
  logic       upd_i = 1'b0;
  logic [7:0] res_o, nxt_o, flags_o;

  int checks = 0;
  int fails  = 0;
  int exp_f  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .st_i(st_i), .upd_i(upd_i), .res_o(res_o), .nxt_o(nxt_o), .flags_o(flags_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int op, int st);
    case (op)
      0:        return ((st >> 3) & 1) ? "R4" : "R2";
      1:        return ((st >> 3) & 1) ? "R4" : "R3";
      5, 6:     return "R6";
      7, 8:     return "R7";
      11:       return "R8";
      12:       return "R9";
      13, 14:   return "R10";
      default:  return "R5";
    endcase
  endfunction

  // Behavioural model of result and next status
  function automatic void model(int op, int a, int b, int st, output int r, output int ns);
    int n, v, z, c, d, s, lo, hi, lc, bb;
    n = (st >> 7) & 1; v = (st >> 6) & 1; z = (st >> 1) & 1; c = st & 1;
    d = (st >> 3) & 1;
    r = a;
    case (op)
      0, 1: begin
        bb = (op == 0) ? b : (~b & 255);
        s  = a + bb + c;
        v  = (((~(a ^ bb)) & (a ^ s) & 128) != 0) ? 1 : 0;
        if (!d) begin
          r = s & 255; c = (s > 255) ? 1 : 0;
        end else if (op == 0) begin
          lo = (a & 15) + (b & 15) + c; lc = 0;
          if (lo > 9) begin lo = lo + 6; lc = 1; end
          hi = (a >> 4) + (b >> 4) + lc; c = 0;
          if (hi > 9) begin hi = hi + 6; c = 1; end
          r = ((hi & 15) << 4) | (lo & 15);
        end else begin
          lo = (a & 15) - (b & 15) - (1 - c); lc = 0;
          if (lo < 0) begin lo = lo + 10; lc = 1; end
          hi = (a >> 4) - (b >> 4) - lc; c = 1;
          if (hi < 0) begin hi = hi + 10; c = 0; end
          r = ((hi & 15) << 4) | (lo & 15);
        end
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      11: begin
        s = a + (~b & 255) + 1;
        c = (s > 255) ? 1 : 0; n = (s >> 7) & 1; z = ((s & 255) == 0) ? 1 : 0;
        r = a;
      end
      12: begin
        r = a; n = (b >> 7) & 1; v = (b >> 6) & 1; z = ((a & b) == 0) ? 1 : 0;
      end
      13, 14: begin
        r = (op == 13) ? (b & ~a & 255) : (b | a);
        z = ((a & b) == 0) ? 1 : 0;
      end
      default: begin
        case (op)
          2:  r = a & b;
          3:  r = a | b;
          4:  r = a ^ b;
          5:  begin c = (b >> 7) & 1; r = (b << 1) & 255; end
          6:  begin c = b & 1; r = b >> 1; end
          7:  begin c = (b >> 7) & 1; r = ((b << 1) | (st & 1)) & 255; end
          8:  begin c = b & 1; r = (b >> 1) | ((st & 1) << 7); end
          9:  r = (b + 1) & 255;
          10: r = (b + 255) & 255;
          default: r = b;
        endcase
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
    endcase
    ns = (st & 8'h3C) | (n << 7) | (v << 6) | (z << 1) | c;
  endfunction

  task automatic apply(int op, int a, int b, int st, bit upd);
    int r, ns;
    string t;
    @(negedge clk);
    chk("R11", "flags_o", flags_o, exp_f);
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; st_i = st[7:0]; upd_i = upd;
    #1;
    model(op, a, b, st, r, ns);
    t = tag_of(op, st);
    chk(t, "res_o", res_o, r);
    chk(t, "nxt_o", nxt_o, ns);
    chk("R1", "nxt_o[5:2]", (nxt_o >> 2) & 15, (st >> 2) & 15);
    if (upd) exp_f = ns;
  endtask

  initial begin
    // R11: reset value holds even with the strobe high
    upd_i = 1'b1; op_i = 4'h0; a_i = 8'hFF; b_i = 8'h01;
    repeat (3) @(negedge clk);
    chk("R11", "flags_o reset", flags_o, 0);
    rst_n = 1'b1;
    upd_i = 1'b0;

    apply(0, 8'h50, 8'h50, 8'h30, 1);   // R2 signed overflow
    apply(0, 8'hFF, 8'h01, 8'h00, 1);   // R2 carry and zero
    apply(0, 8'h99, 8'h01, 8'h08, 1);   // R4 decimal wrap, C=1
    apply(1, 8'h00, 8'h01, 8'h09, 1);   // R4 decimal borrow gives 99
    apply(1, 8'h80, 8'h01, 8'h01, 0);   // R3 overflow on subtract
    apply(1, 8'h05, 8'h05, 8'h01, 1);   // R3 zero, no borrow
    apply(11, 8'h05, 8'h05, 8'h40, 1);  // R8 equal compare keeps V
    apply(11, 8'h04, 8'h05, 8'h00, 1);  // R8 less than
    apply(12, 8'h00, 8'hC0, 8'h01, 1);  // R9 N,V from operand
    apply(6, 8'h00, 8'h01, 8'h80, 1);   // R6 LSR clears N
    apply(5, 8'h00, 8'h80, 8'h00, 1);   // R6 ASL carry out
    apply(8, 8'h00, 8'h00, 8'h01, 1);   // R7 ROR carry into bit 7
    apply(7, 8'h00, 8'h80, 8'h00, 0);   // R7 ROL carry out
    apply(13, 8'h0F, 8'hFF, 8'hC1, 1);  // R10 reset bits
    apply(14, 8'hF0, 8'h0F, 8'hC1, 1);  // R10 set bits, no overlap
    apply(10, 8'h00, 8'h00, 8'h41, 1);  // R5 decrement wraps
    apply(9, 8'h00, 8'hFF, 8'h3C, 1);   // R5 increment to zero

    for (int i = 0; i < 8000; i++) begin
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            bit'($urandom_range(0, 1)));
    end
    @(negedge clk);
    chk("R11", "flags_o final", flags_o, exp_f);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule